// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file on a small synchronous I/O bus. It answers a fixed set of 16-bit port addresses: a single port that controls the processor soft reset and the byte-order mode, and a group of ports from 0x0800 upward. Writes to these ports change control outputs. Some writes store a value. Others raise a level or fire a one-cycle pulse toward a neighbouring block, such as the processor reset line, the indicator lamp, the cache control field, the I/O address map mode, or the lock toggles of two NVRAM banks. Reads return either live state or fixed identification and equipment bytes.

The bus is a plain strobe interface with no back-pressure. The block accepts a read strobe or a write strobe in any cycle, and the two may be asserted together. A write takes effect at the clock edge that samples it. Read data is registered: it is valid in the cycle after the read strobe and is held until the next read. When both strobes arrive together, the read returns the state from before the write. An access to a port the block does not decode has two results. An undecoded read returns all-ones, and an undecoded write is dropped. In both cases the block raises a one-cycle error flag.

Top module: `sysctl_regfile`

## Requirements
- R1: A synchronous reset clears every control output (`cpu_reset_o`, `little_endian_o`, `disk_led_o`, `sysctl_o`, `map_mode_o`, `nv_lock_o`, `addr_err_o`) and sets `rd_data` to 0x00.
- R2: A write to port 0x0092 with data bit 0 set drives `cpu_reset_o` high, and with bit 0 clear drives it low. The level holds through writes to any other port until the next write to 0x0092.
- R3: Data bit 1 of a write to 0x0092 sets `little_endian_o` (1 means little-endian). A read of 0x0092 returns the flag in bit 1 and zero in all other bits.
- R4: Reads of the fixed ports return these constants: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00, and 0x0823 gives 0x03.
- R5: Writes to 0x0800, 0x0802, 0x0803 and 0x0814 change no output and do not raise `addr_err_o`.
- R6: A write to 0x0808 copies data bit 0 to `disk_led_o`.
- R7: A write to 0x0810 pulses `nv_lock_o[0]`, and a write to 0x0812 pulses `nv_lock_o[1]`. Each pulse is high for exactly the one cycle after the write strobe, and the write data has no effect on it.
- R8: A write to 0x081C stores data bits 3:0 on `sysctl_o`. A read of 0x081C returns that field with bits 7:4 zero.
- R9: A write to 0x0850 stores data bit 0 on `map_mode_o`. A read of 0x0850 returns it in bit 0 with all other bits zero.
- R10: A read of an undecoded port returns 0xFF and raises `addr_err_o` for the one cycle after the strobe. A read of 0x0814 returns 0xFF without raising the flag.
- R11: A write to an undecoded port (including the read-only ports 0x080C, 0x0818 and 0x0823) changes no state and raises `addr_err_o` for the one cycle after the strobe.
- R12: `rd_data` is updated only in the cycle after a read strobe and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| addr | input | 16 | Port address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| cpu_reset_o | output | 1 | Held processor soft-reset level |
| little_endian_o | output | 1 | Byte-order mode, 1 = little-endian |
| disk_led_o | output | 1 | Disk activity indicator |
| sysctl_o | output | 4 | System control field |
| map_mode_o | output | 1 | I/O address map mode |
| nv_lock_o | output | 2 | One-cycle lock toggle pulses, bit 0 = bank 1, bit 1 = bank 2 |
| addr_err_o | output | 1 | One-cycle flag for an access to an undecoded port |

## Verification
The assertions check on every cycle that the reset level moves only after a write to its own port. They also check that each lock pulse is traced back to a write of its own address, that the two pulses never coincide, that an undecoded read returns all-ones, and that read data stays unchanged when there is no read strobe. The constant identification bytes, the masking of the control field, the read-back of the byte-order bit, and the absence of side effects for ignored and undecoded writes can only be shown by the bench. It does this with sequences that first load known state and then read that state back through the ports.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int CTL_W   = 4;
  localparam int NV_BANKS = 2;

  // decoded port addresses
  localparam logic [ADDR_W-1:0] P_RSTEND = 16'h0092;
  localparam logic [ADDR_W-1:0] P_CPUCFG = 16'h0800;
  localparam logic [ADDR_W-1:0] P_FEAT   = 16'h0802;
  localparam logic [ADDR_W-1:0] P_STAT   = 16'h0803;
  localparam logic [ADDR_W-1:0] P_LED    = 16'h0808;
  localparam logic [ADDR_W-1:0] P_EQUIP  = 16'h080C;
  localparam logic [ADDR_W-1:0] P_LOCK1  = 16'h0810;
  localparam logic [ADDR_W-1:0] P_LOCK2  = 16'h0812;
  localparam logic [ADDR_W-1:0] P_L2INV  = 16'h0814;
  localparam logic [ADDR_W-1:0] P_KEY    = 16'h0818;
  localparam logic [ADDR_W-1:0] P_CTL    = 16'h081C;
  localparam logic [ADDR_W-1:0] P_L2STAT = 16'h0823;
  localparam logic [ADDR_W-1:0] P_MAP    = 16'h0850;

  // fixed read values
  localparam logic [DATA_W-1:0] V_CPUCFG = 8'hEF;
  localparam logic [DATA_W-1:0] V_FEAT   = 8'hAD;
  localparam logic [DATA_W-1:0] V_STAT   = 8'hE0;
  localparam logic [DATA_W-1:0] V_EQUIP  = 8'h3C;
  localparam logic [DATA_W-1:0] V_XFEAT  = 8'h39;
  localparam logic [DATA_W-1:0] V_KEY    = 8'h00;
  localparam logic [DATA_W-1:0] V_L2STAT = 8'h03;
  localparam logic [DATA_W-1:0] V_NONE   = {DATA_W{1'b1}};

  typedef struct packed {
    logic rstend;
    logic cpucfg;
    logic feat;
    logic stat;
    logic led;
    logic equip;
    logic l2inv;
    logic key;
    logic ctl;
    logic l2stat;
    logic map;
    logic [NV_BANKS-1:0] lock;
  } port_hit_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output port_hit_t         hit,
  output logic              wr_known,
  output logic              rd_known
);
  localparam logic [NV_BANKS*ADDR_W-1:0] LOCK_PORTS = {P_LOCK2, P_LOCK1};

  always_comb begin
    hit.rstend = (addr == P_RSTEND);
    hit.cpucfg = (addr == P_CPUCFG);
    hit.feat   = (addr == P_FEAT);
    hit.stat   = (addr == P_STAT);
    hit.led    = (addr == P_LED);
    hit.equip  = (addr == P_EQUIP);
    hit.l2inv  = (addr == P_L2INV);
    hit.key    = (addr == P_KEY);
    hit.ctl    = (addr == P_CTL);
    hit.l2stat = (addr == P_L2STAT);
    hit.map    = (addr == P_MAP);
  end

  for (genvar b = 0; b < NV_BANKS; b++) begin : g_lock
    assign hit.lock[b] = (addr == LOCK_PORTS[b*ADDR_W +: ADDR_W]);
  end

  // ports accepting writes vs. ports answering reads
  assign wr_known = hit.rstend | hit.cpucfg | hit.feat | hit.stat | hit.led
                  | (|hit.lock) | hit.l2inv | hit.ctl | hit.map;
  assign rd_known = hit.rstend | hit.cpucfg | hit.feat | hit.stat | hit.equip
                  | hit.lock[0] | hit.l2inv | hit.key | hit.ctl | hit.l2stat
                  | hit.map;
endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  input  port_hit_t         hit,
  input  logic              wr_known,
  input  logic              rd_known,
  output logic              cpu_reset_q,
  output logic              endian_q,
  output logic              led_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic              map_q,
  output logic [NV_BANKS-1:0] lock_q,
  output logic              err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_reset_q <= 1'b0;
      endian_q    <= 1'b0;
      led_q       <= 1'b0;
      ctl_q       <= '0;
      map_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      err_q <= (wr_en & ~wr_known) | (rd_en & ~rd_known);
      if (wr_en) begin
        if (hit.rstend) begin
          cpu_reset_q <= wr_data[0];
          endian_q    <= wr_data[1];
        end
        if (hit.led) led_q <= wr_data[0];
        if (hit.ctl) ctl_q <= wr_data[CTL_W-1:0];
        if (hit.map) map_q <= wr_data[0];
      end
    end
  end

  for (genvar b = 0; b < NV_BANKS; b++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) lock_q[b] <= 1'b0;
      else     lock_q[b] <= wr_en & hit.lock[b];
    end

    AST_LOCK_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
      lock_q[b] |-> $past(wr_en && hit.lock[b])); // R7
  end

  AST_RESET_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit.rstend) |=> $stable(cpu_reset_q)); // R2

  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lock_q)); // R7

  AST_ERR_ONLY_UNDECODED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit.l2inv && !rd_en) |=> !err_q); // R5
endmodule

// File: rtl/sysctl_readmux.sv
module sysctl_readmux
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  port_hit_t         hit,
  input  logic              rd_known,
  input  logic              endian_q,
  input  logic [CTL_W-1:0]  ctl_q,
  input  logic              map_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = V_NONE;
    if (hit.rstend)      sel = DATA_W'({endian_q, 1'b0});
    else if (hit.cpucfg) sel = V_CPUCFG;
    else if (hit.feat)   sel = V_FEAT;
    else if (hit.stat)   sel = V_STAT;
    else if (hit.equip)  sel = V_EQUIP;
    else if (hit.lock[0]) sel = V_XFEAT;
    else if (hit.key)    sel = V_KEY;
    else if (hit.ctl)    sel = DATA_W'(ctl_q);
    else if (hit.l2stat) sel = V_L2STAT;
    else if (hit.map)    sel = DATA_W'(map_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R12

  AST_UNDECODED_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_known) |=> (rd_data == V_NONE)); // R10
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              cpu_reset_o,
  output logic              little_endian_o,
  output logic              disk_led_o,
  output logic [CTL_W-1:0]  sysctl_o,
  output logic              map_mode_o,
  output logic [NV_BANKS-1:0] nv_lock_o,
  output logic              addr_err_o
);
  port_hit_t hit;
  logic      wr_known;
  logic      rd_known;

  sysctl_decode u_decode (
    .addr     (addr),
    .hit      (hit),
    .wr_known (wr_known),
    .rd_known (rd_known)
  );

  sysctl_state u_state (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_data     (wr_data),
    .hit         (hit),
    .wr_known    (wr_known),
    .rd_known    (rd_known),
    .cpu_reset_q (cpu_reset_o),
    .endian_q    (little_endian_o),
    .led_q       (disk_led_o),
    .ctl_q       (sysctl_o),
    .map_q       (map_mode_o),
    .lock_q      (nv_lock_o),
    .err_q       (addr_err_o)
  );

  sysctl_readmux u_readmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .hit      (hit),
    .rd_known (rd_known),
    .endian_q (little_endian_o),
    .ctl_q    (sysctl_o),
    .map_q    (map_mode_o),
    .rd_data  (rd_data)
  );

  AST_MAP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == P_MAP) |=> (map_mode_o == $past(wr_data[0]))); // R9
endmodule

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/1ps
module sysctl_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [15:0] addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        cpu_reset_o, little_endian_o, disk_led_o, map_mode_o, addr_err_o;
  logic [3:0]  sysctl_o;
  logic [1:0]  nv_lock_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sysctl_regfile u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cpu_reset_o(cpu_reset_o),
    .little_endian_o(little_endian_o), .disk_led_o(disk_led_o),
    .sysctl_o(sysctl_o), .map_mode_o(map_mode_o), .nv_lock_o(nv_lock_o),
    .addr_err_o(addr_err_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // packed view of control outputs: {cpu_reset, endian, led, ctl[3:0], map, lock[1:0]}
  function automatic logic [31:0] outs();
    return {22'd0, cpu_reset_o, little_endian_o, disk_led_o, sysctl_o, map_mode_o, nv_lock_o};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 outputs after reset", outs(), 0);
    chk("R1 error after reset", addr_err_o, 0);
    chk("R1 rd_data after reset", rd_data, 8'h00);
  endtask

  task automatic t_reset_endian();
    wr(16'h0092, 8'h01);
    chk("R2 reset high", cpu_reset_o, 1);
    chk("R3 endian still 0", little_endian_o, 0);
    wr(16'h0808, 8'h00);
    chk("R2 reset held over other write", cpu_reset_o, 1);
    rd(16'h0092, 8'h00, "R3 read endian 0");
    wr(16'h0092, 8'h03);
    chk("R3 endian set", little_endian_o, 1);
    rd(16'h0092, 8'h02, "R3 read endian 1");
    wr(16'h0092, 8'hFE);
    chk("R2 reset low", cpu_reset_o, 0);
    chk("R3 endian kept", little_endian_o, 1);
  endtask

  task automatic t_ids();
    rd(16'h0800, 8'hEF, "R4 0800");
    rd(16'h0802, 8'hAD, "R4 0802");
    rd(16'h0803, 8'hE0, "R4 0803");
    rd(16'h080C, 8'h3C, "R4 080C");
    rd(16'h0810, 8'h39, "R4 0810");
    rd(16'h0818, 8'h00, "R4 0818");
    rd(16'h0823, 8'h03, "R4 0823");
  endtask

  task automatic t_led_ctl_map();
    wr(16'h0808, 8'hF1);
    chk("R6 led on", disk_led_o, 1);
    wr(16'h0808, 8'h0E);
    chk("R6 led off", disk_led_o, 0);
    wr(16'h0808, 8'h01);
    wr(16'h081C, 8'hA5);
    chk("R8 ctl field", sysctl_o, 4'h5);
    rd(16'h081C, 8'h05, "R8 read ctl");
    wr(16'h081C, 8'h3A);
    rd(16'h081C, 8'h0A, "R8 read ctl 2");
    wr(16'h0850, 8'hFF);
    chk("R9 map on", map_mode_o, 1);
    rd(16'h0850, 8'h01, "R9 read map 1");
    wr(16'h0850, 8'hFE);
    chk("R9 map off", map_mode_o, 0);
    rd(16'h0850, 8'h00, "R9 read map 0");
    wr(16'h0850, 8'h01);
  endtask

  task automatic t_lock();
    logic [31:0] base;
    base = outs();
    @(negedge clk);
    wr_en = 1'b1; addr = 16'h0810; wr_data = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 bank1 pulse", nv_lock_o, 2'b01);
    @(negedge clk);
    chk("R7 bank1 pulse one cycle", nv_lock_o, 2'b00);
    wr(16'h0812, 8'h5A);
    chk("R7 bank2 pulse", nv_lock_o, 2'b10);
    chk("R7 no error", addr_err_o, 0);
    @(negedge clk);
    chk("R7 state unchanged", outs(), base);
  endtask

  task automatic t_ignored();
    logic [31:0] base;
    base = outs();
    wr(16'h0800, 8'hFF);
    chk("R5 0800 no error", addr_err_o, 0);
    wr(16'h0802, 8'h00);
    wr(16'h0803, 8'hFF);
    wr(16'h0814, 8'h00);
    chk("R5 0814 no error", addr_err_o, 0);
    chk("R5 outputs unchanged", outs(), base);
    rd(16'h081C, {4'h0, base[6:3]}, "R5 ctl readback unchanged");
    rd(16'h0800, 8'hEF, "R5 0800 still constant");
  endtask

  task automatic t_undecoded();
    logic [31:0] base;
    base = outs();
    rd(16'h0801, 8'hFF, "R10 undecoded read");
    chk("R10 error raised", addr_err_o, 1);
    @(negedge clk);
    chk("R10 error one cycle", addr_err_o, 0);
    rd(16'h0814, 8'hFF, "R10 0814 read");
    chk("R10 0814 no error", addr_err_o, 0);
    rd(16'h0812, 8'hFF, "R10 0812 read undecoded");
    chk("R10 0812 read error", addr_err_o, 1);
    wr(16'h080C, 8'hFF);
    chk("R11 write-only-read port error", addr_err_o, 1);
    wr(16'h1234, 8'h00);
    chk("R11 undecoded write error", addr_err_o, 1);
    wr(16'h0093, 8'h00);
    chk("R11 near-miss error", addr_err_o, 1);
    chk("R11 state unchanged", outs(), base);
    rd(16'h0092, {6'd0, base[8], 1'b0}, "R11 endian readback unchanged");
  endtask

  task automatic t_hold();
    rd(16'h0803, 8'hE0, "R12 load");
    @(negedge clk);
    addr = 16'h0800;
    @(negedge clk);
    chk("R12 held without strobe", rd_data, 8'hE0);
    wr(16'h081C, 8'h07);
    chk("R12 held over write", rd_data, 8'hE0);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 16'h081C; wr_data = 8'h0C;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R12 simultaneous read sees old", rd_data, 8'h07);
    chk("R8 simultaneous write stored", sysctl_o, 4'hC);
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 outputs after second reset", outs(), 0);
    chk("R1 rd_data after second reset", rd_data, 0);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reset_endian();
    t_ids();
    t_led_ctl_map();
    t_lock();
    t_ignored();
    t_undecoded();
    t_hold();
    wr(16'h0092, 8'h03);
    t_rereset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule